// File: doc/BRIEF.md
# Banked Event Interrupt Aggregator

This block gathers up to 96 single-bit event flags into three 32-bit pending words and drives three level-sensitive interrupt request lines from them. Each request line has its own mask word for every pending bank. A line is high whenever at least one pending bit is enabled by that line's masks, in any bank. It drops only after every enabled pending bit, across all banks, has gone away.

Event sources post an event by presenting a 7-bit event number with a set strobe. Handlers retire an event the same way through a separate clear strobe. In the event number, bits 6:5 choose the bank and bits 4:0 choose the bit within it. A small register port gives direct read and write access to the pending and mask words. It is used to program routing and to inspect or bulk-load pending state.

Request line 0 feeds the highest-level interrupt input, line 1 the middle level and line 2 the lowest. Priority between the lines is left to the interrupt controller downstream.

Top module: `evt_irq_merge`

## Requirements
- R1: A synchronous active-high reset clears all pending words, all mask words and all three request outputs to zero.
- R2: A set strobe with event number N sets pending bit N[4:0] of bank N[6:5] (banks 0 to 2) and leaves every other pending bit unchanged.
- R3: A clear strobe with event number N clears pending bit N[4:0] of bank N[6:5] and leaves every other pending bit unchanged.
- R4: An event number whose bank field N[6:5] equals 3 changes no state, whether it arrives on the set or the clear strobe.
- R5: When set and clear name the same bit in the same cycle, the bit ends up set. When they name different bits, both take effect.
- R6: Request output irq_o[k] is high exactly when, for some bank b, pending word b ANDed with mask word (k,b) is nonzero. The output reflects any set, clear or register write one clock edge after it is presented.
- R7: Clearing an enabled pending bit in one bank leaves a request output high while any other bank still holds a pending bit enabled for that output.
- R8: Register address bits 3:2 select the word kind and bits 1:0 the bank. Kind 0 is pending, and kinds 1, 2 and 3 are the masks of irq_o[0], irq_o[1] and irq_o[2]. Reads are combinational. An address with bank field 3 reads zero, and writes to it are ignored.
- R9: A mask write takes effect at the next clock edge and affects only the addressed output and bank.
- R10: A register write to a pending word replaces its contents. A clear and then a set presented in the same cycle are applied on top of the written value.
- R11: The three request outputs are independent. A mask enabling one output never raises another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set_vld | input | 1 | Set strobe for evt_set_num |
| evt_set_num | input | 7 | Event number to set: bank in bits 6:5, bit in 4:0 |
| evt_clr_vld | input | 1 | Clear strobe for evt_clr_num |
| evt_clr_num | input | 7 | Event number to clear |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address: kind in bits 3:2, bank in bits 1:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq_o | output | 3 | Request lines, index 0 highest level, index 2 lowest |

## Verification
The hardest case to reach from the ports is a line that must stay high while its pending bits drain one bank at a time. That case needs the same output enabled in two different banks, both pending bits raised, and then a clear that removes only one. The directed stimulus programs two banks of one output's masks, raises one event in each bank, and retires them one by one, checking the line after each clear. Same-cycle collisions are driven on purpose: a set against a clear of the same bit, and a pending-word write against both strobes. A long pseudo-random phase then mixes all commands against a bench model.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int EVT_BANKS  = 3;
    localparam int EVT_BANK_W = 32;
    localparam int EVT_OUTS   = 3;

    // Register kind field of the register port address
    typedef enum logic [1:0] {
        KIND_PEND   = 2'd0,
        KIND_MASK_0 = 2'd1,
        KIND_MASK_1 = 2'd2,
        KIND_MASK_2 = 2'd3
    } reg_kind_e;

    // Single-bit select inside a bank word
    function automatic logic [EVT_BANK_W-1:0] bit_onehot(input logic [$clog2(EVT_BANK_W)-1:0] idx);
        logic [EVT_BANK_W-1:0] r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/evt_decode.sv
module evt_decode #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    localparam int SEL_W    = $clog2(NUM_BANKS),
    localparam int BIT_W    = $clog2(BANK_W),
    localparam int EVT_W    = SEL_W + BIT_W
) (
    input  logic                             vld,
    input  logic [EVT_W-1:0]                 num,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] oh_o
);
    logic [SEL_W-1:0] bank;
    logic [BIT_W-1:0] idx;
    logic [BANK_W-1:0] bit_word;

    assign bank     = num[EVT_W-1:BIT_W];
    assign idx      = num[BIT_W-1:0];
    assign bit_word = {{(BANK_W-1){1'b0}}, 1'b1} << idx;

    // A bank field beyond NUM_BANKS-1 matches no lane and is dropped
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
        assign oh_o[b] = (vld && bank == SEL_W'(b)) ? bit_word : '0;
    end
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] set_oh,
    input  logic [BANK_W-1:0] clr_oh,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_data,
    output logic [BANK_W-1:0] pend_d,
    output logic [BANK_W-1:0] pend_q
);
    logic [BANK_W-1:0] base;

    // Order: register write, then clear, then set (set wins)
    always_comb begin
        base   = wr_en ? wr_data : pend_q;
        pend_d = (base & ~clr_oh) | set_oh;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    a_r1_pend_reset: assert property (@(posedge clk) rst |=> (pend_q == '0));

    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        (set_oh != '0) |=> ((pend_q & $past(set_oh)) == $past(set_oh)));

    a_r3_clr_lands: assert property (@(posedge clk) disable iff (rst)
        ((clr_oh & ~set_oh) != '0) |=> ((pend_q & $past(clr_oh & ~set_oh)) == '0));
endmodule

// File: rtl/irq_reduce.sv
module irq_reduce #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] pend_d,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] mask_d,
    output logic                             irq_q
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            hit = hit | (|(pend_d[b] & mask_d[b]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= hit;
    end

    a_r1_irq_reset: assert property (@(posedge clk) rst |=> !irq_q);
endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge
    import evt_irq_pkg::*;
#(
    parameter int NUM_BANKS = EVT_BANKS,
    parameter int BANK_W    = EVT_BANK_W,
    parameter int NUM_IRQ   = EVT_OUTS,
    localparam int SEL_W    = $clog2(NUM_BANKS),
    localparam int BIT_W    = $clog2(BANK_W),
    localparam int EVT_W    = SEL_W + BIT_W,
    localparam int KIND_W   = $clog2(NUM_IRQ + 1),
    localparam int ADDR_W   = KIND_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_set_vld,
    input  logic [EVT_W-1:0]  evt_set_num,
    input  logic              evt_clr_vld,
    input  logic [EVT_W-1:0]  evt_clr_num,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] reg_rdata,
    output logic [NUM_IRQ-1:0] irq_o
);
    logic [NUM_BANKS-1:0][BANK_W-1:0] set_oh, clr_oh;
    logic [NUM_BANKS-1:0][BANK_W-1:0] pend_d, pend_q;
    logic [NUM_IRQ-1:0][NUM_BANKS-1:0][BANK_W-1:0] mask_d, mask_q;
    logic [KIND_W-1:0] kind;
    logic [SEL_W-1:0]  bank;

    assign kind = reg_addr[ADDR_W-1:SEL_W];
    assign bank = reg_addr[SEL_W-1:0];

    evt_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) set_dec_i (
        .vld(evt_set_vld), .num(evt_set_num), .oh_o(set_oh));
    evt_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) clr_dec_i (
        .vld(evt_clr_vld), .num(evt_clr_num), .oh_o(clr_oh));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_hit;
        assign wr_hit = reg_we && kind == KIND_W'(KIND_PEND) && bank == SEL_W'(b);
        pend_bank #(.BANK_W(BANK_W)) bank_i (
            .clk(clk), .rst(rst),
            .set_oh(set_oh[b]), .clr_oh(clr_oh[b]),
            .wr_en(wr_hit), .wr_data(reg_wdata),
            .pend_d(pend_d[b]), .pend_q(pend_q[b]));
    end

    always_comb begin
        mask_d = mask_q;
        for (int k = 0; k < NUM_IRQ; k++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (reg_we && kind == KIND_W'(k + 1) && bank == SEL_W'(b))
                    mask_d[k][b] = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
        irq_reduce #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) red_i (
            .clk(clk), .rst(rst),
            .pend_d(pend_d), .mask_d(mask_d[k]),
            .irq_q(irq_o[k]));

        // R7: with no clear and no register write, a raised line cannot drop
        a_r7_hold_high: assert property (@(posedge clk) disable iff (rst)
            (irq_o[k] && !evt_clr_vld && !reg_we) |=> irq_o[k]);
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == SEL_W'(b)) begin
                if (kind == KIND_W'(KIND_PEND)) reg_rdata = pend_q[b];
                for (int k = 0; k < NUM_IRQ; k++) begin
                    if (kind == KIND_W'(k + 1)) reg_rdata = mask_q[k][b];
                end
            end
        end
    end

    a_r2_set_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(set_oh) <= 1);

    a_r4_set_bank_oob: assert property (@(posedge clk) disable iff (rst)
        (evt_set_num[EVT_W-1:BIT_W] >= SEL_W'(NUM_BANKS)) |-> (set_oh == '0));

    a_r4_clr_bank_oob: assert property (@(posedge clk) disable iff (rst)
        (evt_clr_num[EVT_W-1:BIT_W] >= SEL_W'(NUM_BANKS)) |-> (clr_oh == '0));
endmodule

// File: tb/evt_irq_merge_tb_top.sv
module evt_irq_merge_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        evt_set_vld, evt_clr_vld, reg_we;
    logic [6:0]  evt_set_num, evt_clr_num;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [2:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_pend [3];
    logic [31:0] m_mask [3][3];

    always #2.5 clk = ~clk;

    evt_irq_merge dut_i (
        .clk(clk), .rst(rst),
        .evt_set_vld(evt_set_vld), .evt_set_num(evt_set_num),
        .evt_clr_vld(evt_clr_vld), .evt_clr_num(evt_clr_num),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o));

    function automatic logic [2:0] exp_irq();
        logic [2:0] r = '0;
        for (int k = 0; k < 3; k++)
            for (int b = 0; b < 3; b++)
                if ((m_pend[b] & m_mask[k][b]) != 0) r[k] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        if (a[1:0] == 2'd3) return '0;
        if (a[3:2] == 2'd0) return m_pend[a[1:0]];
        return m_mask[a[3:2] - 1][a[1:0]];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input string req);
        check(req, {29'd0, irq_o}, {29'd0, exp_irq()});
    endtask

    task automatic chk_rd(input string req, input logic [3:0] a);
        reg_addr = a;
        #0.5;
        check(req, reg_rdata, exp_rd(a));
    endtask

    // One clock of stimulus; model updated per R2-R5, R8-R10
    task automatic step(input logic sv, input logic [6:0] sn, input logic cv, input logic [6:0] cn,
                        input logic we, input logic [3:0] a, input logic [31:0] wd);
        @(negedge clk);
        evt_set_vld = sv; evt_set_num = sn;
        evt_clr_vld = cv; evt_clr_num = cn;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        for (int b = 0; b < 3; b++) begin
            logic [31:0] base = m_pend[b];
            if (we && a[3:2] == 2'd0 && a[1:0] == b[1:0]) base = wd;
            if (cv && cn[6:5] == b[1:0]) base = base & ~(32'd1 << cn[4:0]);
            if (sv && sn[6:5] == b[1:0]) base = base | (32'd1 << sn[4:0]);
            m_pend[b] = base;
        end
        if (we && a[3:2] != 2'd0 && a[1:0] != 2'd3) m_mask[a[3:2] - 1][a[1:0]] = wd;
        #1;
        evt_set_vld = 0; evt_clr_vld = 0; reg_we = 0;
    endtask

    task automatic ev_set(input logic [6:0] n);  step(1, n, 0, 0, 0, 0, 0); endtask
    task automatic ev_clr(input logic [6:0] n);  step(0, 0, 1, n, 0, 0, 0); endtask
    task automatic wr(input logic [3:0] a, input logic [31:0] d); step(0, 0, 0, 0, 1, a, d); endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        for (int b = 0; b < 3; b++) begin
            m_pend[b] = 0;
            for (int k = 0; k < 3; k++) m_mask[k][b] = 0;
        end
        check("R1 irq after reset", {29'd0, irq_o}, 32'd0);
        for (int a = 0; a < 16; a++) chk_rd("R1 word after reset", a[3:0]);
    endtask

    task automatic t_set_decode();
        ev_set(7'h25);
        check("R2 bank1 bit5", reg_rdata, 32'h0);   // addr 0 still selects bank0
        chk_rd("R2 bank1 word", 4'b0001);
        chk_rd("R2 bank0 untouched", 4'b0000);
        ev_set(7'h5F);
        chk_rd("R2 bank2 bit31", 4'b0010);
        check("R2 bank2 value", reg_rdata, 32'h8000_0000);
        chk_irq("R6 no masks no irq");
    endtask

    task automatic t_mask_route();
        wr(4'b0101, 32'h0000_0020);   // mask of irq_o[0], bank1
        chk_irq("R9 mask write raises irq0");
        check("R11 only irq0", {29'd0, irq_o}, 32'd1);
        chk_rd("R8 mask read", 4'b0101);
        wr(4'b1110, 32'hFFFF_FFFF);   // irq_o[2] mask, bank2
        check("R11 irq2 joins", {29'd0, irq_o}, 32'd5);
        wr(4'b1110, 32'h0);
        chk_irq("R9 mask removal");
    endtask

    task automatic t_bank3();
        ev_set(7'h65);
        for (int a = 0; a < 3; a++) chk_rd("R4 set bank3 ignored", a[3:0]);
        chk_irq("R4 irq unchanged");
        ev_clr(7'h25 | 7'h60);        // bank 3, bit 5
        chk_rd("R4 clr bank3 ignored", 4'b0001);
        check("R4 bit kept", reg_rdata, 32'h20);
        wr(4'b0111, 32'hDEAD_BEEF);
        chk_rd("R8 bank3 reads zero", 4'b0111);
        chk_irq("R8 bank3 write ignored");
    endtask

    task automatic t_clear();
        ev_clr(7'h25);
        chk_rd("R3 cleared", 4'b0001);
        chk_irq("R3 irq0 drops");
        chk_rd("R3 other bank kept", 4'b0010);
    endtask

    task automatic t_multi_bank();
        wr(4'b1000, 32'h0000_0004);   // irq_o[1], bank0 bit2
        wr(4'b1010, 32'h0000_0100);   // irq_o[1], bank2 bit8
        ev_set(7'h02);
        ev_set(7'h48);
        check("R7 irq1 high", {31'd0, irq_o[1]}, 32'd1);
        ev_clr(7'h02);
        check("R7 irq1 held by bank2", {31'd0, irq_o[1]}, 32'd1);
        chk_irq("R7 full");
        ev_clr(7'h48);
        check("R7 irq1 low", {31'd0, irq_o[1]}, 32'd0);
    endtask

    task automatic t_same_bit();
        step(1, 7'h0A, 1, 7'h0A, 0, 0, 0);
        chk_rd("R5 set wins", 4'b0000);
        step(1, 7'h0B, 1, 7'h0A, 0, 0, 0);
        chk_rd("R5 both apply", 4'b0000);
        check("R5 value", reg_rdata, 32'h0000_0800);
    endtask

    task automatic t_pend_write();
        step(1, 7'h21, 1, 7'h22, 1, 4'b0001, 32'h0000_00F4);
        chk_rd("R10 write then clr then set", 4'b0001);
        check("R10 value", reg_rdata, 32'h0000_00F2);
        wr(4'b1101, 32'h0000_0010);   // irq_o[2] mask bank1
        chk_irq("R10 pending write routes");
        wr(4'b0001, 32'h0);
        chk_irq("R10 pending wipe");
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] wd = $urandom & $urandom;
            step(r[0], r[7:1], r[8], r[15:9], r[16] & r[17], r[21:18], wd);
            chk_irq("R6 random");
            chk_rd("R8 random read", r[25:22]);
        end
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        evt_set_vld = 0; evt_clr_vld = 0; reg_we = 0;
        evt_set_num = 0; evt_clr_num = 0; reg_addr = 0; reg_wdata = 0;
        t_reset();
        t_set_decode();
        t_mask_route();
        t_bank3();
        t_clear();
        t_multi_bank();
        t_same_bit();
        t_pend_write();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule